// File: doc/BRIEF.md
# Two-Stage Zero Counter

This unit returns the number of zero bits that precede the first set bit of a 64-bit operand, counted either from the least significant end (trailing zeros) or from the most significant end (leading zeros). A word-size control picks between a full 64-bit count and a 32-bit count that looks only at the low word. All four operations share one datapath. A leading count is handled by mirroring the active bits and then running the trailing-count path.

The trailing path isolates the lowest set bit as a one-hot vector with `x & (~x + 1)`. It then turns that vector into a bit index with one wide OR per index bit: index bit k is the OR of every one-hot position whose number has bit k set. A register between isolation and encoding splits the work over two cycles. A new operand can enter on every cycle. The unit has no states. Its only control is a two-deep valid pipeline: the front stage register (`FRONT`) feeds the encode stage register (`ENCODE`) on every clock, with no stall transition.

Top module: `cz_count_unit`

## Requirements
- R1: With `in_lead`=0 and `in_word32`=0, the count equals the index of the lowest set bit among bits 63:0.
- R2: With `in_lead`=0 and `in_word32`=1, the count equals the index of the lowest set bit among bits 31:0. Bits 63:32 have no effect.
- R3: With `in_lead`=1 and `in_word32`=0, the count equals 63 minus the index of the highest set bit among bits 63:0.
- R4: With `in_lead`=1 and `in_word32`=1, the count equals 31 minus the index of the highest set bit among bits 31:0. Bits 63:32 have no effect.
- R5: An operand with no set bit in the active width gives a count of 64 in 64-bit mode and 32 in 32-bit mode.
- R6: `out_valid` is high exactly two clock edges after the edge that samples `in_valid` high, and low otherwise. `out_count` belongs to that operand.
- R7: Operands presented on consecutive cycles, with any mix of modes, each produce their own correct result on consecutive cycles.
- R8: `out_count` carries the 7-bit count in bits 6:0. Bits 63:7 are always zero.
- R9: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0 and `out_count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 64 | Value to scan |
| in_lead | input | 1 | 1 = count leading zeros, 0 = count trailing zeros |
| in_word32 | input | 1 | 1 = low 32 bits only, 0 = all 64 bits |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_count | output | 64 | Zero-extended count |

## Verification
In any cycle, the front stage is isolating a new operand while the encode stage turns the previous one-hot vector into a count. The two operands may differ in direction, in width, and in whether they are zero. The bench provokes this overlap with unbroken runs of random operands whose modes change on every cycle, and places zero and single-bit operands directly next to full-width ones. Every output cycle is compared with a bench model of the operand sampled two edges earlier. The valid flag is checked in every cycle, including idle ones.

// File: rtl/cz_pkg.sv
package cz_pkg;
    localparam int unsigned OP_W  = 64;
    localparam int unsigned HALF  = OP_W / 2;
    localparam int unsigned IDX_W = $clog2(OP_W);
    localparam int unsigned CNT_W = IDX_W + 1;

    typedef struct packed {
        logic            vld;
        logic            zero;
        logic            word32;
        logic [OP_W-1:0] onehot;
    } cz_front_t;
endpackage

// File: rtl/cz_front.sv
module cz_front
    import cz_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_operand,
    input  logic            in_lead,
    input  logic            in_word32,
    output cz_front_t       front_q
);
    logic [OP_W-1:0] masked;
    logic [OP_W-1:0] rev_full;
    logic [OP_W-1:0] rev_half;
    logic [OP_W-1:0] src;
    logic [OP_W-1:0] iso;
    cz_front_t       front_d;

    assign masked = in_word32 ? {{HALF{1'b0}}, in_operand[HALF-1:0]} : in_operand;

    for (genvar i = 0; i < OP_W; i++) begin : g_mirror
        assign rev_full[i] = in_operand[OP_W-1-i];
        if (i < HALF) begin : g_lo
            assign rev_half[i] = in_operand[HALF-1-i];
        end else begin : g_hi
            assign rev_half[i] = 1'b0;
        end
    end

    always_comb begin
        src = masked;
        if (in_lead) begin
            src = in_word32 ? rev_half : rev_full;
        end
        iso            = src & (~src + 1'b1);
        front_d.vld    = in_valid;
        front_d.zero   = (src == '0);
        front_d.word32 = in_word32;
        front_d.onehot = iso;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            front_q <= '0;
        end else begin
            front_q <= front_d;
        end
    end

    // R1 R3: the isolated vector never has more than one bit set
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(front_q.onehot));
    // R5: a zero flag comes with an empty vector
    a_r5_zero_empty: assert property (@(posedge clk) disable iff (!rst_n)
        front_q.zero |-> (front_q.onehot == '0));
    // R2 R4: in 32-bit mode nothing above the low word survives
    a_r2_low_word: assert property (@(posedge clk) disable iff (!rst_n)
        front_q.word32 |-> (front_q.onehot[OP_W-1:HALF] == '0));
endmodule

// File: rtl/cz_encode.sv
module cz_encode
    import cz_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cz_front_t        front_q,
    output logic             enc_valid,
    output logic [CNT_W-1:0] enc_count
);
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt_d;

    for (genvar k = 0; k < IDX_W; k++) begin : g_or_bit
        logic [OP_W-1:0] sel;
        for (genvar j = 0; j < OP_W; j++) begin : g_sel
            if (((j >> k) & 1) == 1) begin : g_on
                assign sel[j] = 1'b1;
            end else begin : g_off
                assign sel[j] = 1'b0;
            end
        end
        assign idx[k] = |(front_q.onehot & sel);
    end

    always_comb begin
        cnt_d = {1'b0, idx};
        if (front_q.zero) begin
            cnt_d = front_q.word32 ? CNT_W'(HALF) : CNT_W'(OP_W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_valid <= 1'b0;
            enc_count <= '0;
        end else begin
            enc_valid <= front_q.vld;
            enc_count <= cnt_d;
        end
    end

    // R6: the result strobe follows the front-stage strobe by one edge
    a_r6_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid == $past(front_q.vld));
    // R5: a zero operand yields the active width
    a_r5_width_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(front_q.zero) |->
            (enc_count == ($past(front_q.word32) ? CNT_W'(HALF) : CNT_W'(OP_W))));
    // R2 R4: a 32-bit count never exceeds 32
    a_r4_half_range: assert property (@(posedge clk) disable iff (!rst_n)
        $past(front_q.word32) |-> (enc_count <= CNT_W'(HALF)));
endmodule

// File: rtl/cz_count_unit.sv
module cz_count_unit
    import cz_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_operand,
    input  logic            in_lead,
    input  logic            in_word32,
    output logic            out_valid,
    output logic [OP_W-1:0] out_count
);
    cz_front_t        front_q;
    logic [CNT_W-1:0] enc_count;

    cz_front u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_operand (in_operand),
        .in_lead    (in_lead),
        .in_word32  (in_word32),
        .front_q    (front_q)
    );

    cz_encode u_encode (
        .clk       (clk),
        .rst_n     (rst_n),
        .front_q   (front_q),
        .enc_valid (out_valid),
        .enc_count (enc_count)
    );

    assign out_count = {{(OP_W-CNT_W){1'b0}}, enc_count};

    // R8: the count never exceeds the full width
    a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_count <= OP_W'(OP_W));
endmodule

// File: tb/cz_count_unit_test.sv
module cz_count_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_operand;
    logic        in_lead;
    logic        in_word32;
    logic        out_valid;
    logic [63:0] out_count;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    bit         e1_v, e2_v;
    int         e1_c, e2_c;
    string      e1_t, e2_t;

    always #2 clk = ~clk;

    cz_count_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_lead(in_lead), .in_word32(in_word32),
        .out_valid(out_valid), .out_count(out_count)
    );

    function automatic int ref_cnt(logic [63:0] x, bit lead, bit w32);
        int n = w32 ? 32 : 64;
        int c = 0;
        bit hit = 0;
        for (int i = 0; i < n; i++) begin
            int p = lead ? (n - 1 - i) : i;
            if (!hit) begin
                if (x[p]) hit = 1;
                else c++;
            end
        end
        return c;
    endfunction

    function automatic string tag_of(bit lead, bit w32);
        if (lead && w32) return "R4";
        if (lead)        return "R3";
        if (w32)         return "R2";
        return "R1";
    endfunction

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: check the result due now, then present the next operand
    task automatic step(bit v, logic [63:0] x, bit lead, bit w32);
        @(negedge clk);
        chk("R6", out_valid, e2_v);
        if (e2_v) begin
            chk(e2_t, out_count[6:0], e2_c);
            chk("R8", out_count[63:7], 0);
        end
        e2_v = e1_v; e2_c = e1_c; e2_t = e1_t;
        e1_v = v;
        e1_c = ref_cnt(x, lead, w32);
        e1_t = (x == 0 || (w32 && x[31:0] == 0)) ? "R5" : tag_of(lead, w32);
        in_valid = v; in_operand = x; in_lead = lead; in_word32 = w32;
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; in_valid = 0; in_operand = '0; in_lead = 0; in_word32 = 0;
        e1_v = 0; e2_v = 0; e1_c = 0; e2_c = 0; e1_t = "R1"; e2_t = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", out_valid, 0);
        chk("R9", out_count, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R9", out_valid, 0);
        chk("R9", out_count, 0);

        // directed corners, back to back (R7)
        for (int m = 0; m < 4; m++) step(1, 64'd0, m[0], m[1]);            // R5
        for (int m = 0; m < 4; m++) step(1, 64'd1, m[0], m[1]);
        for (int m = 0; m < 4; m++) step(1, 64'h8000_0000_0000_0000, m[0], m[1]);
        for (int m = 0; m < 4; m++) step(1, 64'h0000_0000_8000_0000, m[0], m[1]);
        for (int m = 0; m < 4; m++) step(1, 64'hFFFF_FFFF_0000_0000, m[0], m[1]); // R2 R4 upper ignored
        for (int m = 0; m < 4; m++) step(1, '1, m[0], m[1]);
        step(0, '1, 0, 0);
        step(0, '1, 1, 1);
        step(1, 64'h0000_0100_0000_0000, 1, 0);
        step(1, 64'h0000_0000_0001_0000, 0, 1);

        // random stream with gaps and changing modes
        for (int n = 0; n < 600; n++) begin
            logic [63:0] x = {$urandom(), $urandom()};
            int sh = $urandom_range(0, 63);
            case ($urandom_range(0, 3))
                0: x = x >> sh;
                1: x = x << sh;
                2: x = 64'd1 << sh;
                default: ;
            endcase
            step($urandom_range(0, 4) != 0, x, $urandom_range(0, 1), $urandom_range(0, 1));
        end
        step(0, '0, 0, 0);
        step(0, '0, 0, 0);
        step(0, '0, 0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule